// File: doc/BRIEF.md
# Reset Line Controller with Synchronized Status

This block drives a bank of independent reset outputs from a small register map. Software asserts or releases each line by writing a bit in one of several 32-bit assert words. Each line's request is carried into the clock domain of the logic it resets through a two-flop synchronizer. That synchronized value is the reset output. It is also brought back into the bus clock through a second two-flop synchronizer, where it appears in a status word.

A status bit reads 0 for an asserted line and 1 for a released one. A build-time mask flips this for chosen lines. The mask equals the status pattern seen when every line is asserted. Each target domain has its own clock-enable input. While a domain's enable is low, the reset outputs and the status of its lines hold still. The assert words still accept writes in that time. Software polling for completion can therefore tell a stalled release apart from a finished one.

Top module: `rstline_ctrl`

## Requirements
- R1: After bus reset every assert word reads 0xFFFFFFFF, every reset output is 1, and each status word reads the matching 32 bits of the polarity mask.
- R2: A write to the word at byte offset 4*m (m = 0..3) stores the data. Bit n of that word drives reset output 32*m+n, where 1 means asserted. The word reads back the written value, so a read-modify-write of one bit leaves the other lines unchanged.
- R3: Lines whose mask bit is 0 report status 0 while asserted and 1 while released. The status words sit at byte offsets 0x10 + 4*m.
- R4: Lines whose mask bit is 1 report status 1 while asserted and 0 while released. The default mask sets lines 5, 17, 40 and 66.
- R5: A reset output and its status bit change only while that line's target domain enable is high. Lines 32*d to 32*d+31 belong to domain d. While the enable is low, both hold their old values even though the assert word has changed. After the enable rises, they reach the new value within a few cycles.
- R6: Writes to the status offsets change neither the assert words nor the status.
- R7: Reads return zero from offsets 0x20 and above and from any offset whose two low bits are not zero. Writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset for the whole block |
| busWe | input | 1 | Write strobe, sampled on the rising edge of clk |
| busAddr | input | 8 | Byte offset of the access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| tgtClk | input | 4 | Clock of each target domain |
| tgtClkEn | input | 4 | Clock enable of each target domain |
| rstOut | output | 128 | Reset outputs, 1 = asserted, each in its domain's clock |

## Verification
A write to a status offset can land in the same bus cycle as a change in the synchronized status of a line that is still settling. To provoke this, the bench releases a word of lines and then writes to that word's status offset on every cycle while the release propagates. The final status must show the released pattern. The assert word must still hold the value written before. A second overlap comes from gating a domain during a write to its assert word. The stored value must update at once while the output and status of that domain stay frozen.

// File: rtl/rstline_pkg.sv
package rstline_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_ASSERT = 2'd1,
    SEL_STATUS = 2'd2
  } rdSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic       wrAssert;
    logic       wrStatus;
    rdSel_e     rdSel;
    logic [7:0] word;
  } strobes_t;
endpackage

// File: rtl/rlc_ctrl.sv
module rlc_ctrl
  import rstline_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 4
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          strb
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strb = '{wrAssert: 1'b0, wrStatus: 1'b0, rdSel: SEL_NONE, word: 8'd0};
    if (aligned) begin
      if (int'(wordIdx) < NUM_WORDS) begin
        strb.rdSel    = SEL_ASSERT;
        strb.word     = 8'(int'(wordIdx));
        strb.wrAssert = busWe;
      end else if (int'(wordIdx) < 2 * NUM_WORDS) begin
        strb.rdSel    = SEL_STATUS;
        strb.word     = 8'(int'(wordIdx) - NUM_WORDS);
        strb.wrStatus = busWe;
      end
    end
  end
endmodule

// File: rtl/rlc_line_sync.sv
module rlc_line_sync (
  input  logic busClk,
  input  logic rst_n,
  input  logic tgtClk,
  input  logic tgtEn,
  input  logic req,
  output logic lineOut,
  output logic busView
);
  logic tgtMeta, tgtQ, busMeta, busQ;

  // Target domain: advances only while its enable is high
  always_ff @(posedge tgtClk or negedge rst_n) begin
    if (!rst_n) begin
      tgtMeta <= 1'b1;
      tgtQ    <= 1'b1;
    end else if (tgtEn) begin
      tgtMeta <= req;
      tgtQ    <= tgtMeta;
    end
  end

  // Back into the bus domain
  always_ff @(posedge busClk or negedge rst_n) begin
    if (!rst_n) begin
      busMeta <= 1'b1;
      busQ    <= 1'b1;
    end else begin
      busMeta <= tgtQ;
      busQ    <= busMeta;
    end
  end

  assign lineOut = tgtQ;
  assign busView = busQ;

  // R5
  gated_freeze_chk: assert property (@(posedge tgtClk) disable iff (!rst_n)
    !tgtEn |=> $stable(lineOut));
endmodule

// File: rtl/rlc_datapath.sv
module rlc_datapath
  import rstline_pkg::*;
#(
  parameter int                 DATA_W    = 32,
  parameter int                 NUM_LINES = 128,
  parameter int                 NUM_DOM   = 4,
  parameter logic [NUM_LINES-1:0] STAT_POL = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobes_t             strb,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic [NUM_DOM-1:0]   tgtClk,
  input  logic [NUM_DOM-1:0]   tgtClkEn,
  output logic [NUM_LINES-1:0] rstOut
);
  localparam int NUM_WORDS     = NUM_LINES / DATA_W;
  localparam int LINES_PER_DOM = NUM_LINES / NUM_DOM;

  logic [NUM_LINES-1:0] assertReg;
  logic [NUM_LINES-1:0] syncBack;
  logic [NUM_LINES-1:0] statusVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) assertReg <= '1;
    else if (strb.wrAssert) assertReg[int'(strb.word)*DATA_W +: DATA_W] <= wrData;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    rlc_line_sync u_sync (
      .busClk (clk),
      .rst_n  (rst_n),
      .tgtClk (tgtClk[i / LINES_PER_DOM]),
      .tgtEn  (tgtClkEn[i / LINES_PER_DOM]),
      .req    (assertReg[i]),
      .lineOut(rstOut[i]),
      .busView(syncBack[i])
    );
  end

  // Asserted line shows its mask bit, released line the inverse
  assign statusVec = ~(syncBack ^ STAT_POL);

  always_comb begin
    unique case (strb.rdSel)
      SEL_ASSERT: rdData = assertReg[int'(strb.word)*DATA_W +: DATA_W];
      SEL_STATUS: rdData = statusVec[int'(strb.word)*DATA_W +: DATA_W];
      default:    rdData = '0;
    endcase
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_wchk
    // R2
    assert_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.wrAssert && strb.word == 8'(w)) |=>
        assertReg[w*DATA_W +: DATA_W] == $past(wrData));
  end

  // R6
  status_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrStatus |=> $stable(assertReg));
endmodule

// File: rtl/rstline_ctrl.sv
module rstline_ctrl
  import rstline_pkg::*;
#(
  parameter int                   ADDR_W    = 8,
  parameter int                   DATA_W    = 32,
  parameter int                   NUM_LINES = 128,
  parameter int                   NUM_DOM   = 4,
  parameter logic [NUM_LINES-1:0] STAT_POL  =
    128'h00000000_00000004_00000100_00020020
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [NUM_DOM-1:0]   tgtClk,
  input  logic [NUM_DOM-1:0]   tgtClkEn,
  output logic [NUM_LINES-1:0] rstOut
);
  localparam int NUM_WORDS = NUM_LINES / DATA_W;

  strobes_t strb;

  rlc_ctrl #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_ctrl (
    .busWe  (busWe),
    .busAddr(busAddr),
    .strb   (strb)
  );

  rlc_datapath #(
    .DATA_W(DATA_W), .NUM_LINES(NUM_LINES), .NUM_DOM(NUM_DOM), .STAT_POL(STAT_POL)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .wrData  (busWrData),
    .rdData  (busRdData),
    .tgtClk  (tgtClk),
    .tgtClkEn(tgtClkEn),
    .rstOut  (rstOut)
  );

  // R7
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr[1:0] != 2'b00 || int'(busAddr[ADDR_W-1:2]) >= 2 * NUM_WORDS)
      |-> busRdData == '0);
endmodule

// File: tb/rstline_ctrl_test.sv
module rstline_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 12;
  localparam logic [127:0] POL = 128'h00000000_00000004_00000100_00020020;

  typedef struct packed {
    logic [1:0]  word;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 32'h0000_0000},
    '{2'd0, 32'hFFFF_FFDF},
    '{2'd1, 32'hA5A5_0F0F},
    '{2'd2, 32'h0000_0004},
    '{2'd3, 32'h8000_0001},
    '{2'd1, 32'hFFFF_FFFF}
  };

  logic         clk = 0, rst_n = 0, busWe = 0;
  logic [7:0]   busAddr = 0;
  logic [31:0]  busWrData = 0, busRdData;
  logic [3:0]   tgtClk = 0, tgtClkEn = 4'hF;
  logic [127:0] rstOut;
  int tests = 0, fails = 0;
  bit done = 0;

  rstline_ctrl uut (
    .clk(clk), .rst_n(rst_n), .busWe(busWe), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .tgtClk(tgtClk), .tgtClkEn(tgtClkEn), .rstOut(rstOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always #6 tgtClk[0] = ~tgtClk[0];
  always #7 tgtClk[1] = ~tgtClk[1];
  always #8 tgtClk[2] = ~tgtClk[2];
  always #9 tgtClk[3] = ~tgtClk[3];

  function automatic logic [31:0] expStatus(input logic [31:0] asrt, input logic [31:0] pol);
    return (asrt & pol) | (~asrt & ~pol);
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWe = 0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #2 d = busRdData;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, st0, prev;
    logic [31:0] words [4];
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int w = 0; w < 4; w++) words[w] = 32'hFFFF_FFFF;

    // R1 reset state, R4 mask pattern while all asserted
    for (int w = 0; w < 4; w++) begin
      busRead(8'(4*w), rd);
      check("R1 assert word", 128'(rd), 128'hFFFF_FFFF);
      busRead(8'(16 + 4*w), rd);
      check("R1/R4 status word", 128'(rd), 128'(POL[w*32 +: 32]));
    end
    check("R1 rstOut", rstOut, '1);

    // R2 R3 R4 vector table
    foreach (VECS[k]) begin
      busWrite(8'(4*VECS[k].word), VECS[k].data);
      words[VECS[k].word] = VECS[k].data;
      settle();
      busRead(8'(4*VECS[k].word), rd);
      check("R2 readback", 128'(rd), 128'(VECS[k].data));
      check("R2 rstOut slice", 128'(rstOut[VECS[k].word*32 +: 32]), 128'(VECS[k].data));
      busRead(8'(16 + 4*VECS[k].word), rd);
      check("R3/R4 status", 128'(rd),
            128'(expStatus(VECS[k].data, POL[VECS[k].word*32 +: 32])));
    end

    // R2 read-modify-write of one bit
    busRead(8'h04, rd);
    busWrite(8'h04, rd ^ 32'h0000_0200);
    words[1] = rd ^ 32'h0000_0200;
    settle();
    busRead(8'h04, rd);
    check("R2 rmw word", 128'(rd), 128'(words[1]));
    check("R2 rmw line41", 128'(rstOut[41]), 128'(words[1][9]));
    check("R2 rmw others", 128'(rstOut[127:0]),
          {words[3], words[2], words[1], words[0]});

    // R5 gated domain 2
    busRead(8'h18, prev);
    tgtClkEn[2] = 0;
    busWrite(8'h08, 32'h0000_0000);
    words[2] = 0;
    settle();
    busRead(8'h08, rd);
    check("R5 assert word updates while gated", 128'(rd), 128'h0);
    busRead(8'h18, rd);
    check("R5 status frozen while gated", 128'(rd), 128'(prev));
    check("R5 rstOut frozen while gated", 128'(rstOut[95:64]), 128'h0000_0004);
    tgtClkEn[2] = 1;
    settle();
    busRead(8'h18, rd);
    check("R5 status after ungate", 128'(rd), 128'(expStatus(32'h0, POL[95:64])));
    check("R4 inverted line 66 released", 128'(rd[2]), 128'h0);
    check("R3 normal line 64 released", 128'(rd[0]), 128'h1);

    // R6 status writes while a release settles
    busWrite(8'h00, 32'h0000_0000);
    words[0] = 0;
    for (int c = 0; c < SETTLE; c++) begin
      @(negedge clk);
      busWe = 1; busAddr = 8'h10; busWrData = 32'h1234_5678;
    end
    @(negedge clk);
    busWe = 0;
    settle();
    busRead(8'h10, st0);
    check("R6 status after status writes", 128'(st0), 128'(expStatus(32'h0, POL[31:0])));
    busRead(8'h00, rd);
    check("R6 assert word untouched", 128'(rd), 128'h0);

    // R7 unmapped and misaligned
    busRead(8'h20, rd); check("R7 read 0x20", 128'(rd), 128'h0);
    busRead(8'hFC, rd); check("R7 read 0xFC", 128'(rd), 128'h0);
    busRead(8'h05, rd); check("R7 misaligned read", 128'(rd), 128'h0);
    busWrite(8'h20, 32'hFFFF_FFFF);
    busWrite(8'h01, 32'hFFFF_FFFF);
    settle();
    for (int w = 0; w < 4; w++) begin
      busRead(8'(4*w), rd);
      check("R7 writes change nothing", 128'(rd), 128'(words[w]));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule